// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

The block sits beside an instruction fetch unit. Every cycle that fetch presents an instruction address, the buffer searches the set chosen by the low address bits. It compares the stored tags of all four ways at once and returns a predicted next-fetch address in the same cycle. On a hit, the stored entry decides the prediction. An unconditional branch always redirects to its taken target. A conditional branch follows the top bit of its 2-bit history counter and picks either the stored taken target or the stored fall-through target. On a miss, the prediction is not taken and the address is the sequential one, the fetch address plus the instruction size.

Once a branch resolves, the execution side sends one update. The update carries the branch address, both targets, the outcome and a flag that marks the branch as conditional. If the branch is already present, its entry is refreshed and its counter steps toward the outcome. Otherwise the branch is allocated into its set. An empty way is taken first. When the set is full, a per-set rotating pointer picks the way.

The update interface is a valid/ready stream whose ready is held high: every beat offered with valid is consumed on that clock edge, and no back-pressure is ever applied. The lookup side is plain control: the prediction is a combinational function of the fetch address and of the stored contents.

Top module: `brtgt_buf`

## Requirements
- R1: A lookup with fetch_valid high that matches no valid entry gives pred_hit=0 and pred_taken=0, and pred_target equals fetch_pc+4.
- R2: A lookup that hits a conditional entry whose counter has bit 1 set gives pred_hit=1, pred_taken=1, and pred_target equal to the stored taken target.
- R3: A lookup that hits a conditional entry whose counter has bit 1 clear gives pred_hit=1, pred_taken=0, and pred_target equal to the stored fall-through target.
- R4: A lookup that hits an unconditional entry (upd_cond=0 at its last update) gives pred_taken=1 and the stored taken target, whatever its counter holds.
- R5: An update that misses allocates an entry with counter 2 (weakly taken) when upd_taken=1, and counter 1 (weakly not taken) when upd_taken=0. The counter encodings are 0 and 1 for not taken and 2 and 3 for taken.
- R6: An update that hits overwrites both targets and the conditional flag. It steps the counter up by one on taken and down by one on not taken, saturating at 3 and at 0.
- R7: Allocation takes the lowest-numbered invalid way of the set. When all four ways are valid, it takes the way named by the set's pointer. Every allocation sets that pointer to the way after the one written, modulo 4. Pointers start at way 0.
- R8: A lookup in the same cycle as an update to the same set sees the contents as they were before that update. The update is visible from the next cycle on.
- R9: Reset (rst_n low) invalidates every entry and returns every pointer to way 0.
- R10: With fetch_valid low, pred_hit and pred_taken are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | A lookup is requested this cycle |
| fetch_pc | input | ADDR_W | Address being fetched |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Prediction redirects fetch |
| pred_target | output | ADDR_W | Predicted next-fetch address |
| upd_valid | input | 1 | Resolved-branch beat offered |
| upd_ready | output | 1 | Beat accepted (always high) |
| upd_pc | input | ADDR_W | Resolved branch address |
| upd_taken_tgt | input | ADDR_W | Target when taken |
| upd_fall_tgt | input | ADDR_W | Target when not taken |
| upd_taken | input | 1 | Resolved outcome |
| upd_cond | input | 1 | Branch is conditional |

## Verification
A lookup and an update can fall in the same cycle, and the hard case is when both address the same set, or the very same branch. The bench provokes this in a directed step that offers a new branch for allocation while fetch looks up that same address. It also provokes it throughout a long random phase that draws both addresses from a few tags and sets, so collisions are frequent. The bench's model applies each update only after the edge, so every comparison expects the pre-update contents in the colliding cycle and the new contents from the cycle after.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] hist_t;

  localparam hist_t HIST_STRONG_NT = 2'd0;
  localparam hist_t HIST_WEAK_NT   = 2'd1;
  localparam hist_t HIST_WEAK_TK   = 2'd2;
  localparam hist_t HIST_STRONG_TK = 2'd3;

  // saturating step of the 2-bit history toward the resolved outcome
  function automatic hist_t hist_step(hist_t h, logic taken);
    hist_t r;
    if (taken) r = (h == HIST_STRONG_TK) ? h : h + 2'd1;
    else       r = (h == HIST_STRONG_NT) ? h : h - 2'd1;
    return r;
  endfunction

  function automatic hist_t hist_seed(logic taken);
    return taken ? HIST_WEAK_TK : HIST_WEAK_NT;
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 26,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  // read port A (lookup)
  input  logic [IDX_W-1:0]               a_set,
  output logic [WAYS-1:0]                a_valid,
  output logic [WAYS-1:0][TAG_W-1:0]     a_tag,
  output logic [WAYS-1:0][ADDR_W-1:0]    a_tt,
  output logic [WAYS-1:0][ADDR_W-1:0]    a_nt,
  output logic [WAYS-1:0][1:0]           a_hist,
  output logic [WAYS-1:0]                a_cond,
  // read port B (update side)
  input  logic [IDX_W-1:0]               b_set,
  output logic [WAYS-1:0]                b_valid,
  output logic [WAYS-1:0][TAG_W-1:0]     b_tag,
  output logic [WAYS-1:0][1:0]           b_hist,
  // write port
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_set,
  input  logic [WAY_W-1:0]               wr_way,
  input  logic [TAG_W-1:0]               wr_tag,
  input  logic [ADDR_W-1:0]              wr_tt,
  input  logic [ADDR_W-1:0]              wr_nt,
  input  logic [1:0]                     wr_hist,
  input  logic                           wr_cond
);

  logic [WAYS-1:0]              vld_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q  [SETS];
  logic [WAYS-1:0][ADDR_W-1:0]  tt_q   [SETS];
  logic [WAYS-1:0][ADDR_W-1:0]  nt_q   [SETS];
  logic [WAYS-1:0][1:0]         hist_q [SETS];
  logic [WAYS-1:0]              cond_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      tt_q[wr_set][wr_way]   <= wr_tt;
      nt_q[wr_set][wr_way]   <= wr_nt;
      hist_q[wr_set][wr_way] <= wr_hist;
      cond_q[wr_set][wr_way] <= wr_cond;
    end
  end

  always_comb begin
    a_valid = vld_q[a_set];
    a_tag   = tag_q[a_set];
    a_tt    = tt_q[a_set];
    a_nt    = nt_q[a_set];
    a_hist  = hist_q[a_set];
    a_cond  = cond_q[a_set];
    b_valid = vld_q[b_set];
    b_tag   = tag_q[b_set];
    b_hist  = hist_q[b_set];
  end

endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit_any,
  output logic [WAY_W-1:0]           hit_idx
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_idx = WAY_W'(w);
  end

  assign hit_any = |hit_vec;

endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [WAYS-1:0]  set_valid,
  input  logic             alloc_en,
  output logic [WAY_W-1:0] victim
);

  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] free_idx;
  logic             free_found;

  // lowest-numbered empty way wins
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!set_valid[w] && !free_found) begin
        free_idx   = WAY_W'(w);
        free_found = 1'b1;
      end
    end
  end

  assign victim = free_found ? free_idx : ptr_q[set_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (alloc_en) begin
      ptr_q[set_idx] <= victim + WAY_W'(1);
    end
  end

endmodule

// File: rtl/brtgt_buf.sv
module brtgt_buf
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SETS        = 16,
  parameter int WAYS        = 4,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_taken_tgt,
  input  logic [ADDR_W-1:0] upd_fall_tgt,
  input  logic              upd_taken,
  input  logic              upd_cond
);

  localparam int OFF_W = $clog2(INSTR_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = $clog2(WAYS);

  // lookup side
  logic [IDX_W-1:0]             lk_set;
  logic [TAG_W-1:0]             lk_tag;
  logic [WAYS-1:0]              a_valid, a_cond;
  logic [WAYS-1:0][TAG_W-1:0]   a_tag;
  logic [WAYS-1:0][ADDR_W-1:0]  a_tt, a_nt;
  logic [WAYS-1:0][1:0]         a_hist;
  logic [WAYS-1:0]              hit_vec;
  logic                         lk_hit;
  logic [WAY_W-1:0]             lk_way;
  logic                         lk_redirect;

  // update side
  logic [IDX_W-1:0]             up_set;
  logic [TAG_W-1:0]             up_tag;
  logic [WAYS-1:0]              b_valid;
  logic [WAYS-1:0][TAG_W-1:0]   b_tag;
  logic [WAYS-1:0][1:0]         b_hist;
  logic [WAYS-1:0]              up_hit_vec;
  logic                         up_hit;
  logic [WAY_W-1:0]             up_way_hit;
  logic [WAY_W-1:0]             up_victim;
  logic                         up_fire;
  logic [WAY_W-1:0]             wr_way;
  hist_t                        wr_hist;

  assign lk_set = fetch_pc[OFF_W +: IDX_W];
  assign lk_tag = fetch_pc[ADDR_W-1 -: TAG_W];
  assign up_set = upd_pc[OFF_W +: IDX_W];
  assign up_tag = upd_pc[ADDR_W-1 -: TAG_W];

  assign upd_ready = 1'b1;
  assign up_fire   = upd_valid && upd_ready;

  btb_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_set(lk_set), .a_valid(a_valid), .a_tag(a_tag), .a_tt(a_tt),
    .a_nt(a_nt), .a_hist(a_hist), .a_cond(a_cond),
    .b_set(up_set), .b_valid(b_valid), .b_tag(b_tag), .b_hist(b_hist),
    .wr_en(up_fire), .wr_set(up_set), .wr_way(wr_way), .wr_tag(up_tag),
    .wr_tt(upd_taken_tgt), .wr_nt(upd_fall_tgt), .wr_hist(wr_hist),
    .wr_cond(upd_cond)
  );

  btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid(a_valid), .tags(a_tag), .key(lk_tag),
    .hit_vec(hit_vec), .hit_any(lk_hit), .hit_idx(lk_way)
  );

  btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .valid(b_valid), .tags(b_tag), .key(up_tag),
    .hit_vec(up_hit_vec), .hit_any(up_hit), .hit_idx(up_way_hit)
  );

  btb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .set_idx(up_set), .set_valid(b_valid),
    .alloc_en(up_fire && !up_hit), .victim(up_victim)
  );

  // refresh in place or allocate
  assign wr_way  = up_hit ? up_way_hit : up_victim;
  assign wr_hist = up_hit ? hist_step(b_hist[up_way_hit], upd_taken)
                          : hist_seed(upd_taken);

  // prediction
  assign lk_redirect = !a_cond[lk_way] || a_hist[lk_way][1];
  assign pred_hit    = fetch_valid && lk_hit;
  assign pred_taken  = pred_hit && lk_redirect;

  always_comb begin
    if (!pred_hit)       pred_target = fetch_pc + ADDR_W'(INSTR_BYTES);
    else if (pred_taken) pred_target = a_tt[lk_way];
    else                 pred_target = a_nt[lk_way];
  end

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int ADDR_W      = 32,
  parameter int WAYS        = 4,
  parameter int INSTR_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_target,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic [WAYS-1:0]   hit_vec
);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (!pred_hit && !pred_taken));

  // R1
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !pred_hit) |->
      (!pred_taken && pred_target == fetch_pc + ADDR_W'(INSTR_BYTES)));

  // R7
  single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R8
  upd_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid ##1 (fetch_valid && fetch_pc == $past(upd_pc)) |-> pred_hit);

endmodule

bind brtgt_buf btb_checker #(
  .ADDR_W(ADDR_W), .WAYS(WAYS), .INSTR_BYTES(INSTR_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
  .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
  .upd_valid(upd_valid), .upd_pc(upd_pc), .hit_vec(hit_vec)
);

// File: tb/sim_brtgt_buf.sv
module sim_brtgt_buf;
  localparam int CLK_P = 10;
  localparam int AW    = 32;
  localparam int NSET  = 16;
  localparam int NWAY  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          pred_hit, pred_taken, upd_ready;
  logic [AW-1:0] pred_target;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0, upd_taken_tgt = '0, upd_fall_tgt = '0;
  logic          upd_taken = 1'b0, upd_cond = 1'b0;

  brtgt_buf #(.ADDR_W(AW), .SETS(NSET), .WAYS(NWAY), .INSTR_BYTES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken_tgt(upd_taken_tgt), .upd_fall_tgt(upd_fall_tgt),
    .upd_taken(upd_taken), .upd_cond(upd_cond)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural model: per set, per way
  bit            mv   [NSET][NWAY];
  logic [AW-1:0] mpc  [NSET][NWAY];
  logic [AW-1:0] mtt  [NSET][NWAY];
  logic [AW-1:0] mnt  [NSET][NWAY];
  int            mh   [NSET][NWAY];
  bit            mc   [NSET][NWAY];
  int            mptr [NSET];

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phase = "R9";

  function automatic int set_of(logic [AW-1:0] pc);
    return int'((pc >> 2) % NSET);
  endfunction

  function automatic int find(logic [AW-1:0] pc);
    int s = set_of(pc);
    for (int w = 0; w < NWAY; w++)
      if (mv[s][w] && (mpc[s][w] >> 2) == (pc >> 2)) return w;
    return -1;
  endfunction

  task automatic model_clear();
    for (int s = 0; s < NSET; s++) begin
      mptr[s] = 0;
      for (int w = 0; w < NWAY; w++) mv[s][w] = 0;
    end
  endtask

  task automatic model_update();
    int s = set_of(upd_pc);
    int w = find(upd_pc);
    if (w >= 0) begin
      if (upd_taken) mh[s][w] = (mh[s][w] < 3) ? mh[s][w] + 1 : 3;
      else           mh[s][w] = (mh[s][w] > 0) ? mh[s][w] - 1 : 0;
    end else begin
      w = -1;
      for (int k = 0; k < NWAY; k++) if (!mv[s][k] && w < 0) w = k;
      if (w < 0) w = mptr[s];
      mptr[s] = (w + 1) % NWAY;
      mh[s][w] = upd_taken ? 2 : 1;
    end
    mv[s][w] = 1; mpc[s][w] = upd_pc; mtt[s][w] = upd_taken_tgt;
    mnt[s][w] = upd_fall_tgt; mc[s][w] = upd_cond;
  endtask

  task automatic compare();
    int s = set_of(fetch_pc);
    int w = fetch_valid ? find(fetch_pc) : -1;
    bit e_hit = (w >= 0);
    bit e_tk = 0;
    logic [AW-1:0] e_tgt = fetch_pc + 4;
    string req;
    if (!fetch_valid) req = "R10";
    else if (!e_hit) req = "R1";
    else if (!mc[s][w]) req = "R4";
    else if (mh[s][w] >= 2) req = "R2";
    else req = "R3";
    if (e_hit) begin
      e_tk  = !mc[s][w] || (mh[s][w] >= 2);
      e_tgt = e_tk ? mtt[s][w] : mnt[s][w];
    end
    checks++;
    if (pred_hit !== e_hit || pred_taken !== e_tk || pred_target !== e_tgt) begin
      errors++;
      $display("FAIL %s/%s pc=%h got hit=%0b tk=%0b tgt=%h exp hit=%0b tk=%0b tgt=%h",
               phase, req, fetch_pc, pred_hit, pred_taken, pred_target,
               e_hit, e_tk, e_tgt);
    end
    if (upd_ready !== 1'b1) begin
      errors++;
      $display("FAIL %s upd_ready got %0b exp 1", phase, upd_ready);
    end
  endtask

  task automatic cyc(bit fv, logic [AW-1:0] fpc, bit uv, logic [AW-1:0] upc,
                     logic [AW-1:0] utt, logic [AW-1:0] unt, bit utk, bit uc);
    @(negedge clk);
    fetch_valid = fv; fetch_pc = fpc;
    upd_valid = uv; upd_pc = upc; upd_taken_tgt = utt; upd_fall_tgt = unt;
    upd_taken = utk; upd_cond = uc;
    #1 compare();
    @(posedge clk);
    if (uv) model_update();
  endtask

  task automatic look(logic [AW-1:0] pc);
    cyc(1, pc, 0, '0, '0, '0, 0, 0);
  endtask

  task automatic upd(logic [AW-1:0] pc, logic [AW-1:0] tt, bit tk, bit c);
    cyc(0, '0, 1, pc, tt, pc + 4, tk, c);
  endtask

  function automatic logic [AW-1:0] mk(int tag, int s);
    return AW'((tag << 6) | (s << 2));
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    phase = "R9";  look(32'h100); look(32'h2000);

    phase = "R5";
    upd(32'h1000, 32'h9000, 1, 1); look(32'h1000);
    upd(32'h1104, 32'h9100, 0, 1); look(32'h1104);

    phase = "R6";
    upd(32'h1000, 32'h9004, 0, 1); look(32'h1000);
    upd(32'h1000, 32'h9008, 0, 1); look(32'h1000);
    upd(32'h1000, 32'h9008, 0, 1); look(32'h1000);
    for (int i = 0; i < 4; i++) begin upd(32'h1000, 32'h900c, 1, 1); look(32'h1000); end
    upd(32'h1000, 32'h900c, 0, 1); look(32'h1000);

    phase = "R4";
    upd(32'h2208, 32'hA000, 0, 0); upd(32'h2208, 32'hA004, 0, 0);
    upd(32'h2208, 32'hA008, 0, 0); look(32'h2208);

    phase = "R7";
    for (int t = 1; t <= 6; t++) upd(mk(t, 5), AW'(32'hB000 + t * 16), 1, 1);
    for (int t = 1; t <= 6; t++) look(mk(t, 5));

    phase = "R8";
    cyc(1, 32'h3300, 1, 32'h3300, 32'hC000, 32'h3304, 1, 1);
    look(32'h3300);
    cyc(1, 32'h3300, 1, 32'h3300, 32'hC100, 32'h3304, 0, 1);
    look(32'h3300);

    phase = "R10"; cyc(0, 32'h1000, 0, '0, '0, '0, 0, 0);

    phase = "R8";
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a = mk(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)));
      logic [AW-1:0] b = ($urandom_range(0, 3) == 0) ? a
                         : mk(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)));
      cyc(bit'($urandom_range(0, 7) != 0), a, bit'($urandom_range(0, 1)), b,
          AW'($urandom), AW'($urandom), bit'($urandom_range(0, 1)),
          bit'($urandom_range(0, 3) != 0));
    end

    phase = "R9";
    @(negedge clk) rst_n = 1'b0; upd_valid = 1'b0;
    model_clear();
    @(negedge clk) rst_n = 1'b1;
    look(32'h1000); look(mk(3, 5));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule